// File: doc/BRIEF.md
# Hash Padding Word Generator

This block produces the closing words of an MD5 or SHA-1 message as a stream of 32-bit little-endian words. The caller has already delivered the message in whole words. At start it presents the algorithm select, the number of bytes already sent in whole words, and a partial tail word of 0 to 3 bytes with its byte count. The block then emits, over a valid/ready handshake, a tail word that carries the end-of-message marker, a run of zero words, and two words that hold the message length in bits. After the last length word is taken, it raises a single-cycle data-end request and returns to idle.

The zero-word count and the order of the length words depend on the algorithm. The count comes from the byte position inside the 64-byte block. SHA-1 takes that position with the tail bytes included. MD5 takes it from the whole-word count plus the four bytes of the marker word. The longest sequence is 18 words, so a whole finalization always fits an empty 32-entry receive FIFO downstream.

Top module: `hpad_gen`

## Requirements
- R1: After synchronous reset, word_valid, data_end, busy and len_err are all low.
- R2: The first word of a sequence keeps the low tail_len bytes of tail_bytes, with byte lane k at bits [8k+7:8k]. It clears the bytes above them and puts 0x80 in lane tail_len. For tail_len = 0 the word is exactly 0x00000080.
- R3: With mode = 1 (SHA-1), let p = (done_bytes + tail_len) mod 64. Let q = 56 - p when p < 56, and 120 - p otherwise. The tail word is then followed by (q - 1) / 4 zero words, with integer division.
- R4: With mode = 0 (MD5), let p = (done_bytes + 4) mod 64. The tail word is followed by (120 - p) / 4 zero words when p > 56, and by (56 - p) / 4 zero words otherwise.
- R5: In MD5 mode, the two final words are the low and then the high 32 bits of L = (done_bytes + tail_len) * 8.
- R6: In SHA-1 mode, the 64-bit value L is written as eight bytes, most significant byte first. Those bytes are packed into two little-endian words, first bytes first, and the first word is sent first.
- R7: A sequence never carries more than 32 words.
- R8: While word_valid is high and word_ready is low, word_valid stays high and word_data holds its value. The stream advances only on a cycle where both are high.
- R9: data_end is high for exactly one cycle, the cycle after the last length word is accepted. In the following cycle busy is low.
- R10: While busy is high, start is ignored. The sequence in flight keeps the values latched at its start, and no second sequence or len_err follows.
- R11: A start seen while idle with tail_len > 3 emits no words. It raises len_err for the single following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a finalization; sampled only while idle |
| mode | input | 1 | 0 = MD5, 1 = SHA-1 |
| done_bytes | input | 64 | Bytes already delivered in whole words |
| tail_bytes | input | 32 | Leftover tail bytes, lane 0 in bits [7:0] |
| tail_len | input | 3 | Number of valid tail bytes, 0 to 3 |
| word_valid | output | 1 | word_data holds a word to transfer |
| word_ready | input | 1 | Downstream accepts the word |
| word_data | output | 32 | Outgoing padding word |
| data_end | output | 1 | One-cycle end-of-data request |
| busy | output | 1 | A sequence is in progress |
| len_err | output | 1 | One-cycle flag for a rejected tail_len |

## Verification
Two events can fall in the same cycle: a new start request, and the data-end pulse that closes the sequence in flight. Both also collide with the acceptance of the last word. The bench raises start in exactly the cycle where data_end is seen, and again in the middle of a sequence with a tail_len that would otherwise be rejected. It judges the result by requiring three things: the words match the first request alone, no second stream or len_err appears, and busy falls the cycle after the pulse. Changing ready patterns also place stalls on the tail word, on the zero run and on each length word.

// File: rtl/hpad_pkg.sv
package hpad_pkg;

    parameter int WORD_W     = 32;
    parameter int CNT_W      = 64;
    parameter int LEN_W      = 3;
    parameter int FIFO_DEPTH = 32;
    parameter int BLK_BYTES  = 64;

    localparam int LANES   = WORD_W / 8;
    localparam int NBW_W   = $clog2(LANES);
    localparam int IDX_W   = $clog2(BLK_BYTES) + 1;
    localparam int ZCNT_W  = $clog2(BLK_BYTES / LANES) + 1;
    localparam int WSENT_W = $clog2(FIFO_DEPTH) + 1;

    typedef enum logic {
        MODE_MD5  = 1'b0,
        MODE_SHA1 = 1'b1
    } hp_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TAIL,
        ST_ZERO,
        ST_LEN0,
        ST_LEN1,
        ST_DONE
    } hp_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] tail_word;
        logic [ZCNT_W-1:0] zeros;
        logic [WORD_W-1:0] len_first;
        logic [WORD_W-1:0] len_second;
    } hp_plan_t;

    function automatic logic [WORD_W-1:0] bswap_word(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        for (int k = 0; k < LANES; k++) begin
            r[8*k +: 8] = w[8*(LANES-1-k) +: 8];
        end
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] mark_tail(input logic [WORD_W-1:0] t,
                                                   input logic [NBW_W-1:0]  nbw);
        logic [WORD_W-1:0] r;
        for (int k = 0; k < LANES; k++) begin
            if (k < int'(nbw))       r[8*k +: 8] = t[8*k +: 8];
            else if (k == int'(nbw)) r[8*k +: 8] = 8'h80;
            else                     r[8*k +: 8] = 8'h00;
        end
        return r;
    endfunction

    function automatic logic [ZCNT_W-1:0] zero_words(input hp_mode_e          m,
                                                    input logic [CNT_W-1:0] bc,
                                                    input logic [NBW_W-1:0] nbw);
        logic [CNT_W-1:0] s;
        logic [IDX_W+1:0] idx;
        logic [IDX_W+1:0] pad;
        if (m == MODE_SHA1) begin
            s   = bc + CNT_W'(nbw);
            idx = (IDX_W+2)'(s[IDX_W-2:0]);
            pad = (idx < (IDX_W+2)'(56)) ? (IDX_W+2)'(56) - idx : (IDX_W+2)'(120) - idx;
            return ZCNT_W'((pad - (IDX_W+2)'(1)) >> 2);
        end else begin
            s   = bc + CNT_W'(LANES);
            idx = (IDX_W+2)'(s[IDX_W-2:0]);
            if (idx > (IDX_W+2)'(56)) return ZCNT_W'(((IDX_W+2)'(120) - idx) >> 2);
            else                      return ZCNT_W'(((IDX_W+2)'(56) - idx) >> 2);
        end
    endfunction

endpackage

// File: rtl/hpad_plan.sv
module hpad_plan
    import hpad_pkg::*;
(
    input  hp_mode_e               mode,
    input  logic [CNT_W-1:0]       done_bytes,
    input  logic [WORD_W-1:0]      tail_bytes,
    input  logic [NBW_W-1:0]       nbw,
    output hp_plan_t               plan
);

    logic [CNT_W-1:0] total_bytes;
    logic [CNT_W-1:0] bit_len;

    always_comb begin
        total_bytes     = done_bytes + CNT_W'(nbw);
        bit_len         = total_bytes << 3;
        plan.tail_word  = mark_tail(tail_bytes, nbw);
        plan.zeros      = zero_words(mode, done_bytes, nbw);
        if (mode == MODE_SHA1) begin
            plan.len_first  = bswap_word(bit_len[CNT_W-1:WORD_W]);
            plan.len_second = bswap_word(bit_len[WORD_W-1:0]);
        end else begin
            plan.len_first  = bit_len[WORD_W-1:0];
            plan.len_second = bit_len[CNT_W-1:WORD_W];
        end
    end

endmodule

// File: rtl/hpad_seq.sv
module hpad_seq
    import hpad_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  hp_plan_t          plan_in,
    input  logic              word_ready,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_data,
    output logic              data_end,
    output logic              busy
);

    hp_state_e          state;
    hp_plan_t           plan_q;
    logic [ZCNT_W-1:0]  zleft;
    logic [WSENT_W-1:0] wsent;
    logic               xfer;

    assign xfer = word_valid && word_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            plan_q <= '0;
            zleft  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (go) begin
                    plan_q <= plan_in;
                    state  <= ST_TAIL;
                end
                ST_TAIL: if (word_ready) begin
                    zleft <= plan_q.zeros;
                    state <= (plan_q.zeros != '0) ? ST_ZERO : ST_LEN0;
                end
                ST_ZERO: if (word_ready) begin
                    zleft <= zleft - ZCNT_W'(1);
                    if (zleft == ZCNT_W'(1)) state <= ST_LEN0;
                end
                ST_LEN0: if (word_ready) state <= ST_LEN1;
                ST_LEN1: if (word_ready) state <= ST_DONE;
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        word_valid = 1'b0;
        word_data  = '0;
        case (state)
            ST_TAIL: begin word_valid = 1'b1; word_data = plan_q.tail_word;  end
            ST_ZERO: begin word_valid = 1'b1; word_data = '0;                end
            ST_LEN0: begin word_valid = 1'b1; word_data = plan_q.len_first;  end
            ST_LEN1: begin word_valid = 1'b1; word_data = plan_q.len_second; end
            default: ;
        endcase
    end

    assign data_end = (state == ST_DONE);
    assign busy     = (state != ST_IDLE);

    // words handed over in the current sequence, for the depth check
    always_ff @(posedge clk) begin
        if (rst)       wsent <= '0;
        else if (go && !busy) wsent <= '0;
        else if (xfer) wsent <= wsent + WSENT_W'(1);
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!word_valid && !data_end)); // R1

    AST_WORD_LIMIT: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> (wsent < WSENT_W'(FIFO_DEPTH))); // R7

    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
        (word_valid && !word_ready) |=> (word_valid && $stable(word_data))); // R8

    AST_END_PULSE: assert property (@(posedge clk) disable iff (rst)
        data_end |=> (!data_end && !busy)); // R9

    AST_END_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LEN1 && word_ready) |=> data_end); // R9

    AST_PLAN_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(plan_q)); // R10

endmodule

// File: rtl/hpad_gen.sv
module hpad_gen
    import hpad_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              mode,
    input  logic [CNT_W-1:0]  done_bytes,
    input  logic [WORD_W-1:0] tail_bytes,
    input  logic [LEN_W-1:0]  tail_len,
    output logic              word_valid,
    input  logic              word_ready,
    output logic [WORD_W-1:0] word_data,
    output logic              data_end,
    output logic              busy,
    output logic              len_err
);

    hp_plan_t plan;
    logic     len_ok;
    logic     go;

    assign len_ok = (tail_len < LEN_W'(LANES));
    assign go     = start && !busy && len_ok;

    hpad_plan u_plan (
        .mode       (hp_mode_e'(mode)),
        .done_bytes (done_bytes),
        .tail_bytes (tail_bytes),
        .nbw        (tail_len[NBW_W-1:0]),
        .plan       (plan)
    );

    hpad_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .go         (go),
        .plan_in    (plan),
        .word_ready (word_ready),
        .word_valid (word_valid),
        .word_data  (word_data),
        .data_end   (data_end),
        .busy       (busy)
    );

    always_ff @(posedge clk) begin
        if (rst) len_err <= 1'b0;
        else     len_err <= start && !busy && !len_ok;
    end

    AST_ERR_STAYS_IDLE: assert property (@(posedge clk) disable iff (rst)
        len_err |-> (!busy && !word_valid)); // R11

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
        len_err |=> !len_err); // R11

endmodule

// File: tb/hpad_gen_test.sv
module hpad_gen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        mode = 1'b0;
    logic [63:0] done_bytes = '0;
    logic [31:0] tail_bytes = '0;
    logic [2:0]  tail_len = '0;
    logic        word_ready = 1'b0;
    logic        word_valid;
    logic [31:0] word_data;
    logic        data_end;
    logic        busy;
    logic        len_err;

    int nchk  = 0;
    int nfail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    hpad_gen uut (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .done_bytes(done_bytes), .tail_bytes(tail_bytes), .tail_len(tail_len),
        .word_valid(word_valid), .word_ready(word_ready), .word_data(word_data),
        .data_end(data_end), .busy(busy), .len_err(len_err)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int exp_zeros(input bit m, input logic [63:0] bc, input int nbw);
        logic [63:0] s;
        int p, q;
        if (m) begin
            s = bc + 64'(nbw);
            p = int'(s[5:0]);
            q = (p < 56) ? 56 - p : 120 - p;
            return (q - 1) / 4;
        end
        s = bc + 64'd4;
        p = int'(s[5:0]);
        return (p > 56) ? (120 - p) / 4 : (56 - p) / 4;
    endfunction

    task automatic run_case(input string name, input bit m, input logic [63:0] bc,
                            input logic [31:0] tl, input int nbw,
                            input logic [7:0] pat, input bit poke);
        logic [31:0] exp_q[$];
        logic [31:0] got_q[$];
        logic [31:0] tw;
        logic [63:0] l;
        logic [31:0] hold_data;
        bit          hold_pend;
        bit          seen_end;
        int          nz;
        int          cyc;
        string       zreq;
        string       lreq;

        tw = (nbw == 0) ? 32'h0 : (tl & (32'hFFFF_FFFF >> (8 * (4 - nbw))));
        tw = tw | (32'h80 << (8 * nbw));
        exp_q.push_back(tw);
        nz = exp_zeros(m, bc, nbw);
        for (int k = 0; k < nz; k++) exp_q.push_back(32'h0);
        l = (bc + 64'(nbw)) * 64'd8;
        if (m) begin
            exp_q.push_back({l[39:32], l[47:40], l[55:48], l[63:56]});
            exp_q.push_back({l[7:0], l[15:8], l[23:16], l[31:24]});
        end else begin
            exp_q.push_back(l[31:0]);
            exp_q.push_back(l[63:32]);
        end
        zreq = m ? "R3" : "R4";
        lreq = m ? "R6" : "R5";

        @(negedge clk);
        start = 1'b1; mode = m; done_bytes = bc; tail_bytes = tl; tail_len = 3'(nbw);
        word_ready = pat[0];
        @(negedge clk);
        start = 1'b0;
        done_bytes = ~bc; tail_bytes = ~tl; mode = ~m;
        hold_pend = 0; seen_end = 0; cyc = 0; hold_data = '0;
        while (!seen_end && cyc < 200) begin
            word_ready = pat[cyc % 8];
            if (poke && cyc == 3) begin start = 1'b1; tail_len = 3'd6; end
            else if (poke && cyc == 4) begin start = 1'b0; tail_len = 3'd1; end
            #1;
            if (hold_pend) begin
                chk({name, " R8 valid held"}, 64'(word_valid), 64'd1);
                chk({name, " R8 data held"}, 64'(word_data), 64'(hold_data));
            end
            hold_pend = word_valid && !word_ready;
            hold_data = word_data;
            if (word_valid && word_ready) got_q.push_back(word_data);
            if (data_end) begin
                seen_end = 1;
                chk({name, " R9 end after last word"}, 64'(got_q.size()), 64'(exp_q.size()));
                if (poke) start = 1'b1;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        #1;
        chk({name, " R9 end seen"}, 64'(seen_end), 64'd1);
        chk({name, " R9 pulse one cycle"}, 64'(data_end), 64'd0);
        chk({name, " R9 idle after end"}, 64'(busy), 64'd0);
        chk({name, " R7 word count"}, 64'(got_q.size() <= 32), 64'd1);
        chk({name, " ", zreq, " total words"}, 64'(got_q.size()), 64'(exp_q.size()));
        for (int k = 0; k < got_q.size() && k < exp_q.size(); k++) begin
            if (k == 0)
                chk({name, " R2 tail word"}, 64'(got_q[k]), 64'(exp_q[k]));
            else if (k >= exp_q.size() - 2)
                chk({name, " ", lreq, " length word"}, 64'(got_q[k]), 64'(exp_q[k]));
            else
                chk({name, " ", zreq, " zero word"}, 64'(got_q[k]), 64'(exp_q[k]));
        end
        if (poke) begin
            for (int k = 0; k < 6; k++) begin
                @(negedge clk); #1;
                chk({name, " R10 no second stream"}, 64'(word_valid | busy), 64'd0);
                chk({name, " R10 no len_err"}, 64'(len_err), 64'd0);
            end
        end
        @(negedge clk);
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 valid", 64'(word_valid), 64'd0);
        chk("R1 data_end", 64'(data_end), 64'd0);
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 len_err", 64'(len_err), 64'd0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic test_bad_len();
        @(negedge clk);
        start = 1'b1; tail_len = 3'd5; mode = 1'b1; done_bytes = 64'd8;
        @(negedge clk);
        start = 1'b0; tail_len = 3'd0;
        #1;
        chk("R11 len_err raised", 64'(len_err), 64'd1);
        chk("R11 no words", 64'(word_valid | busy), 64'd0);
        @(negedge clk); #1;
        chk("R11 len_err one cycle", 64'(len_err), 64'd0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); #1;
            chk("R11 stays idle", 64'(word_valid | busy), 64'd0);
        end
    endtask

    initial begin
        word_ready = 1'b1;
        test_reset();
        run_case("md5_empty",   1'b0, 64'd0,           32'h0,        0, 8'hFF, 0);
        run_case("md5_wrap",    1'b0, 64'd56,          32'hAABBCCDD, 3, 8'hFF, 0);
        run_case("sha_nozero",  1'b1, 64'd52,          32'h11223344, 2, 8'hFF, 0);
        run_case("sha_wrap",    1'b1, 64'h2_0000_003C, 32'h55667788, 1, 8'b1011_0010, 0);
        run_case("md5_big",     1'b0, 64'h3_0000_0010, 32'hCAFEF00D, 1, 8'b0110_0101, 0);
        run_case("sha_empty",   1'b1, 64'd0,           32'hDEADBEEF, 0, 8'b1100_1100, 0);
        run_case("md5_full3",   1'b0, 64'd124,         32'h01020304, 2, 8'b1001_1111, 0);
        test_bad_len();
        run_case("sha_restart", 1'b1, 64'd200,         32'h0A0B0C0D, 3, 8'b1110_0111, 1);
        run_case("md5_restart", 1'b0, 64'd48,          32'h0,        0, 8'b0101_0101, 1);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule